// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests for a processor core and decides which one the sequencer should service next. There are thirteen sources. One is a nonmaskable power-down request. Six are active-low external pins. The rest are single-cycle requests from internal peripherals. Every external pin passes through a two-flop synchronizer. Each source is then either edge-latched or followed as a live level, depending on its kind and, for three pins, on a control bit. The pending requests are ANDed with a software mask register. The highest-priority survivor produces a one-cycle `take` pulse and a vector index for the sequencer.

Software has several controls:
- A write-only force/clear port sets or drops latched requests.
- A global enable, driven by the core's enable and disable instructions, gates all servicing, power-down included.
- A nesting bit chooses between preemption by higher priorities and strictly sequential service.
- Any write to the mask register blocks servicing for one cycle after the write.

The sequencer signals the end of a handler with `isr_done`.

The sequencing is a three-state machine:
- `ST_ARMED` is the state in which a take may be issued.
- `ST_HOLD` is entered on any mask write (transition *mask_write*, from any state). It always returns to `ST_ARMED` (transition *hold_done*).
- `ST_ACK` is entered from `ST_ARMED` when a take fires (transition *fire*). It returns to `ST_ARMED` on the next cycle (transition *ack_done*) unless a mask write sends it to `ST_HOLD`.

`ST_ARMED` stays in place when nothing fires (transition *idle*).

Top module: `ic_prio_ctrl`

## Requirements
- R1: After reset the following hold: `take` is low, the mask register is all zero, the configurable pins are level-sensitive, nesting is off, global servicing is enabled and no handler is in service.
- R2: Vector index equals priority rank, with 0 the highest. The ranks are: 0 power-down, 1 pin IRQ2 (`irq_pin_n[0]`), 2 level pin L1 (`irq_pin_n[1]`), 3 level pin L0 (`irq_pin_n[2]`), 4 port-0 transmit (`periph_req[1]`), 5 port-0 receive (`periph_req[2]`), 6 edge pin E (`irq_pin_n[3]`), 7 byte-DMA done (`periph_req[3]`), 8 pin IRQ1 (`irq_pin_n[4]`), 9 pin IRQ0 (`irq_pin_n[5]`), 10 timer (`periph_req[4]`), 11 software A (`periph_req[5]`), 12 software B (`periph_req[6]`). Power-down is `periph_req[0]`.
- R3: Mask bit i enables source i for i from 1 to 12. A masked edge request stays pending and is taken once its mask bit is set.
- R4: Source 0 is taken whatever the value of mask bit 0.
- R5: Control bits [0], [1] and [2] make sources 9, 8 and 1 edge-sensitive when 1 and level-sensitive when 0. Sources 2 and 3 are always level-sensitive. Source 6 and all internal requests are always edge-latched. A level request that is withdrawn before it is taken produces no take.
- R6: External pins are active low and synchronized by two flops. A level-mode pin that goes low before clock edge n gives `take` high after edge n+2. An edge-mode pin gives it after edge n+3.
- R7: When `fc_wr` is high, each set bit of `fc_set` latches that source and each set bit of `fc_clr` drops it. Set wins over clear. Neither has any effect on a source that is in level mode.
- R8: `take` is not raised after the clock edge that writes the mask, nor after the edge that follows it.
- R9: `gie_off` blocks every source, including source 0, from the second edge after it. `gie_on` re-enables servicing, and `gie_off` wins if both are high. Pending latches survive while servicing is disabled.
- R10: Control bit [3] is 0 for sequential service, where no take occurs while any source is in service. When it is 1, a take occurs only for a source of higher priority than all sources in service. `isr_done` retires the highest-priority source in service.
- R11: `take` lasts one cycle and never appears in two consecutive cycles. `vec` is valid with it and holds afterwards. The edge latch of the taken source is cleared. An internal request pulse before edge n gives `take` after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_n | input | 6 | Active-low external interrupt pins |
| periph_req | input | 7 | Single-cycle internal request pulses, bit 0 power-down |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 13 | New mask value, bit i for source i |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Sensitivity bits [2:0], nesting bit [3] |
| fc_wr | input | 1 | Force/clear write strobe |
| fc_set | input | 13 | Sources to force pending |
| fc_clr | input | 13 | Sources to clear |
| gie_on | input | 1 | Global enable pulse |
| gie_off | input | 1 | Global disable pulse |
| isr_done | input | 1 | Handler return pulse |
| take | output | 1 | Take-interrupt pulse to the sequencer |
| vec | output | 4 | Index of the source taken |

## Verification
Several requests are raised in the same cycle and then retired one at a time. The order of the vectors shows whether the fixed priority and the sequential retirement are right. Each pin is held low, released while servicing is off, and then re-enabled. This separates latched edge requests from live level requests, and the configurable pins are driven in both modes so that the one-edge difference in latency is visible. Mask writes, force/clear writes and global disables are placed next to pending requests, which exposes the two blocked cycles, the precedence of set over clear, and the fact that power-down ignores the mask but obeys the disable. A long random phase mixes all of these stimuli against a cycle model that the bench builds from the requirements.

// File: rtl/ic_prio_pkg.sv
`timescale 1ns/1ps
package ic_prio_pkg;
    localparam int SRC_N    = 13;
    localparam int EXT_N    = 6;
    localparam int INT_N    = 7;
    localparam int CTL_W    = 4;
    localparam int NEST_BIT = 3;
    localparam int VEC_W    = $clog2(SRC_N);

    typedef enum logic [1:0] {
        SK_INTERNAL,
        SK_EDGE_PIN,
        SK_LEVEL_PIN,
        SK_CFG_PIN
    } src_kind_e;

    // kind of each priority rank
    function automatic src_kind_e kind_of(input int rank);
        case (rank)
            1, 8, 9: return SK_CFG_PIN;
            2, 3:    return SK_LEVEL_PIN;
            6:       return SK_EDGE_PIN;
            default: return SK_INTERNAL;
        endcase
    endfunction

    // pin index for external ranks, request line for internal ranks
    function automatic int line_of(input int rank);
        case (rank)
            0:  return 0;
            1:  return 0;
            2:  return 1;
            3:  return 2;
            4:  return 1;
            5:  return 2;
            6:  return 3;
            7:  return 3;
            8:  return 4;
            9:  return 5;
            10: return 4;
            11: return 5;
            default: return 6;
        endcase
    endfunction

    // control bit that selects edge mode for configurable ranks
    function automatic int cfg_of(input int rank);
        case (rank)
            1:       return 2;
            8:       return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/ic_src_slice.sv
`timescale 1ns/1ps
module ic_src_slice
    import ic_prio_pkg::*;
#(
    parameter src_kind_e KIND        = SK_INTERNAL,
    parameter int        SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic pulse,
    input  logic edge_mode,
    input  logic force_set,
    input  logic force_clr,
    input  logic take_clr,
    output logic req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   raw;
    logic                   edge_ev;
    logic                   lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ~pin_n};
            prev_q <= raw;
        end
    end

    assign raw = sync_q[SYNC_STAGES-1];

    generate
        if (KIND == SK_LEVEL_PIN) begin : g_level
            assign lvl = 1'b1;
        end else if (KIND == SK_CFG_PIN) begin : g_cfg
            assign lvl = ~edge_mode;
        end else begin : g_edge
            assign lvl = 1'b0;
        end
    endgenerate

    assign edge_ev = (raw & ~prev_q) | pulse;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (lvl)
            pend_q <= 1'b0;
        else
            pend_q <= (pend_q & ~(force_clr | take_clr)) | edge_ev | force_set;
    end

    assign req = lvl ? raw : pend_q;
endmodule

// File: rtl/ic_prio_pick.sv
`timescale 1ns/1ps
module ic_prio_pick #(
    parameter int N = 13,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] reqs,
    output logic         valid,
    output logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (reqs[i]) idx = W'(i);
        end
        valid  = |reqs;
        onehot = valid ? (N'(1) << idx) : '0;
    end
endmodule

// File: rtl/ic_ctrl_fsm.sv
`timescale 1ns/1ps
module ic_ctrl_fsm #(
    parameter int N = 13,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cand_valid,
    input  logic [W-1:0] cand_idx,
    input  logic [N-1:0] cand_onehot,
    input  logic         mask_wr,
    input  logic         gie,
    input  logic         nest_en,
    input  logic         isr_done,
    output logic         fire,
    output logic         take,
    output logic [W-1:0] vec,
    output logic [N-1:0] svc
);
    typedef enum logic [1:0] {ST_ARMED, ST_HOLD, ST_ACK} ctl_state_e;

    ctl_state_e   state_q, state_nx;
    logic [N-1:0] svc_low;
    logic [N-1:0] at_or_above;
    logic         svc_ok;

    assign svc_low     = svc & (~svc + N'(1));
    assign at_or_above = (cand_onehot << 1) - N'(1);
    assign svc_ok      = (svc == '0) || (nest_en && ((svc & at_or_above) == '0));

    always_comb begin
        fire     = 1'b0;
        state_nx = state_q;
        unique case (state_q)
            ST_ARMED: begin
                fire = ~mask_wr & gie & cand_valid & svc_ok;
                if (mask_wr)   state_nx = ST_HOLD;
                else if (fire) state_nx = ST_ACK;
                else           state_nx = ST_ARMED;
            end
            ST_HOLD:  state_nx = mask_wr ? ST_HOLD : ST_ARMED;
            ST_ACK:   state_nx = mask_wr ? ST_HOLD : ST_ARMED;
            default:  state_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take <= 1'b0;
            vec  <= '0;
            svc  <= '0;
        end else begin
            take <= fire;
            if (fire) vec <= cand_idx;
            svc  <= (isr_done ? (svc & ~svc_low) : svc) | (fire ? cand_onehot : '0);
        end
    end
endmodule

// File: rtl/ic_prio_ctrl.sv
`timescale 1ns/1ps
module ic_prio_ctrl
    import ic_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXT_N-1:0] irq_pin_n,
    input  logic [INT_N-1:0] periph_req,
    input  logic             mask_wr,
    input  logic [SRC_N-1:0] mask_wdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             fc_wr,
    input  logic [SRC_N-1:0] fc_set,
    input  logic [SRC_N-1:0] fc_clr,
    input  logic             gie_on,
    input  logic             gie_off,
    input  logic             isr_done,
    output logic             take,
    output logic [VEC_W-1:0] vec
);
    localparam logic [SRC_N-1:0] UNMASKABLE = SRC_N'(1);

    logic [SRC_N-1:0] mask_q;
    logic [CTL_W-1:0] ctl_q;
    logic             gie_q;
    logic             nest_en;
    logic [SRC_N-1:0] req_w;
    logic [SRC_N-1:0] eff_w;
    logic [SRC_N-1:0] pin_w;
    logic [SRC_N-1:0] pulse_w;
    logic [SRC_N-1:0] emode_w;
    logic [SRC_N-1:0] take_clr_w;
    logic             cand_valid;
    logic [VEC_W-1:0] cand_idx;
    logic [SRC_N-1:0] cand_onehot;
    logic             fire;
    logic [SRC_N-1:0] svc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctl_q  <= '0;
            gie_q  <= 1'b1;
        end else begin
            if (mask_wr) mask_q <= mask_wdata;
            if (ctl_wr)  ctl_q  <= ctl_wdata;
            if (gie_off)     gie_q <= 1'b0;
            else if (gie_on) gie_q <= 1'b1;
        end
    end

    assign nest_en    = ctl_q[NEST_BIT];
    assign take_clr_w = fire ? cand_onehot : '0;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        localparam src_kind_e K = kind_of(i);
        localparam int        L = line_of(i);
        if (K == SK_INTERNAL) begin : g_int
            assign pin_w[i]   = 1'b1;
            assign pulse_w[i] = periph_req[L];
        end else begin : g_ext
            assign pin_w[i]   = irq_pin_n[L];
            assign pulse_w[i] = 1'b0;
        end
        assign emode_w[i] = ctl_q[cfg_of(i)];

        ic_src_slice #(.KIND(K), .SYNC_STAGES(SYNC_STAGES)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (pin_w[i]),
            .pulse     (pulse_w[i]),
            .edge_mode (emode_w[i]),
            .force_set (fc_wr & fc_set[i]),
            .force_clr (fc_wr & fc_clr[i]),
            .take_clr  (take_clr_w[i]),
            .req       (req_w[i])
        );
    end

    assign eff_w = req_w & (mask_q | UNMASKABLE);

    ic_prio_pick #(.N(SRC_N), .W(VEC_W)) u_pick (
        .reqs   (eff_w),
        .valid  (cand_valid),
        .idx    (cand_idx),
        .onehot (cand_onehot)
    );

    ic_ctrl_fsm #(.N(SRC_N), .W(VEC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_valid  (cand_valid),
        .cand_idx    (cand_idx),
        .cand_onehot (cand_onehot),
        .mask_wr     (mask_wr),
        .gie         (gie_q),
        .nest_en     (nest_en),
        .isr_done    (isr_done),
        .fire        (fire),
        .take        (take),
        .vec         (vec),
        .svc         (svc_q)
    );
endmodule

// File: rtl/ic_prio_ctrl_chk.sv
`timescale 1ns/1ps
module ic_prio_ctrl_chk
    import ic_prio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             take,
    input logic [VEC_W-1:0] vec,
    input logic             mask_wr,
    input logic             gie_off,
    input logic [SRC_N-1:0] mask_q,
    input logic [SRC_N-1:0] svc_q,
    input logic             nest_en
);
    logic [SRC_N-1:0] mask_d;
    logic [SRC_N-1:0] svc_d;
    logic             nest_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_d <= '0;
            svc_d  <= '0;
            nest_d <= 1'b0;
        end else begin
            mask_d <= mask_q;
            svc_d  <= svc_q;
            nest_d <= nest_en;
        end
    end

    // R11
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    // R8
    mask_hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> !take);

    // R8
    mask_hold_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> ##1 !take);

    // R9
    gie_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gie_off |=> ##1 !take);

    // R2
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (int'(vec) < SRC_N));

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (vec != '0) && (int'(vec) < SRC_N)) |-> mask_d[vec]);

    // R10
    sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !nest_d) |-> (svc_d == '0));
endmodule

bind ic_prio_ctrl ic_prio_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .vec     (vec),
    .mask_wr (mask_wr),
    .gie_off (gie_off),
    .mask_q  (mask_q),
    .svc_q   (svc_q),
    .nest_en (nest_en)
);

// File: tb/ic_prio_ctrl_test.sv
`timescale 1ns/1ps
module ic_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  pin_n;
    logic [6:0]  preq;
    logic        mask_wr;
    logic [12:0] mask_wd;
    logic        ctl_wr;
    logic [3:0]  ctl_wd;
    logic        fc_wr;
    logic [12:0] fc_s, fc_c;
    logic        gon, goff, done;
    logic        take;
    logic [3:0]  vec;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ic_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(pin_n), .periph_req(preq),
        .mask_wr(mask_wr), .mask_wdata(mask_wd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wd),
        .fc_wr(fc_wr), .fc_set(fc_s), .fc_clr(fc_c), .gie_on(gon), .gie_off(goff),
        .isr_done(done), .take(take), .vec(vec)
    );

    // source tables from R2/R5: 0 internal, 1 edge pin, 2 level pin, 3 configurable pin
    function automatic int kind(input int i);
        case (i)
            6:       return 1;
            2, 3:    return 2;
            1, 8, 9: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int line(input int i);
        case (i)
            0: return 0;  1: return 0;  2: return 1;  3: return 2;
            4: return 1;  5: return 2;  6: return 3;  7: return 3;
            8: return 4;  9: return 5;  10: return 4; 11: return 5;
            default: return 6;
        endcase
    endfunction

    function automatic int cbit(input int i);
        case (i)
            1: return 2;
            8: return 1;
            default: return 0;
        endcase
    endfunction

    // cycle model of the requirements
    bit [5:0]  m_s1, m_s2, m_pv;
    bit [12:0] m_pend, m_mask, m_svc;
    bit [3:0]  m_ctl;
    bit        m_gie;
    int        m_st;
    bit        m_take;
    int        m_vec;

    task automatic m_reset();
        m_s1 = '0; m_s2 = '0; m_pv = '0;
        m_pend = '0; m_mask = '0; m_svc = '0; m_ctl = '0;
        m_gie = 1'b1; m_st = 0; m_take = 1'b0; m_vec = 0;
    endtask

    task automatic m_step();
        bit [12:0] req, ev, lvl, eff, nx, tk, frc, clr, low;
        int cand;
        bit ok, fire, raw;
        for (int i = 0; i < 13; i++) begin
            int k = kind(i);
            int l = line(i);
            lvl[i] = (k == 2) || (k == 3 && !m_ctl[cbit(i)]);
            if (k == 0) begin
                raw = 1'b0;
                ev[i] = preq[l];
            end else begin
                raw = m_s2[l];
                ev[i] = m_s2[l] & ~m_pv[l];
            end
            req[i] = lvl[i] ? raw : m_pend[i];
        end
        eff = req & (m_mask | 13'd1);
        cand = -1;
        for (int i = 12; i >= 0; i--) if (eff[i]) cand = i;
        ok = (m_svc == 0) || (m_ctl[3] && cand >= 0 && ((m_svc & ((13'd2 << cand) - 1)) == 0));
        fire = (m_st == 0) && !mask_wr && m_gie && cand >= 0 && ok;
        tk  = fire ? (13'd1 << cand) : 13'd0;
        frc = fc_wr ? fc_s : 13'd0;
        clr = fc_wr ? fc_c : 13'd0;
        for (int i = 0; i < 13; i++)
            nx[i] = lvl[i] ? 1'b0 : ((m_pend[i] & ~(clr[i] | tk[i])) | ev[i] | frc[i]);
        low = m_svc & (~m_svc + 13'd1);
        m_svc = (done ? (m_svc & ~low) : m_svc) | tk;
        m_pend = nx;
        if (ctl_wr) m_ctl = ctl_wd;
        if (mask_wr) m_mask = mask_wd;
        if (goff) m_gie = 1'b0;
        else if (gon) m_gie = 1'b1;
        m_st = mask_wr ? 1 : (fire ? 2 : 0);
        m_take = fire;
        if (fire) m_vec = cand;
        m_pv = m_s2; m_s2 = m_s1; m_s1 = ~pin_n;
    endtask

    task automatic check(input string tag, input bit cond, input string what, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_strobes();
        preq = '0; mask_wr = 0; ctl_wr = 0; fc_wr = 0; fc_s = '0; fc_c = '0;
        gon = 0; goff = 0; done = 0;
    endtask

    task automatic tick(input string tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, take === m_take, "take", int'(take), int'(m_take));
        if (m_take) check(tag, int'(vec) == m_vec, "vec", int'(vec), m_vec);
        clear_strobes();
    endtask

    task automatic expect_out(input string tag, input bit t, input int v);
        check(tag, take === t, "take", int'(take), int'(t));
        if (t) check(tag, int'(vec) == v, "vec", int'(vec), v);
    endtask

    task automatic wait_take(input string tag, input int exp, input int maxc);
        int got = -1;
        for (int c = 0; c < maxc; c++) begin
            tick(tag);
            if (take) begin
                got = int'(vec);
                break;
            end
        end
        check(tag, got == exp, "taken vec", got, exp);
        tick("R11");
        check("R11", take == 1'b0, "take after take", int'(take), 0);
    endtask

    task automatic drain();
        for (int c = 0; c < 8; c++) begin
            done = 1;
            tick("R10");
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; pin_n = 6'h3F; mask_wd = '0; ctl_wd = '0;
        clear_strobes();
        m_reset();
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R1", take == 1'b0, "take in reset", int'(take), 0);
        end
        rst_n = 1;
        tick("R1"); tick("R1");

        // R4 power-down with mask all zero; R11 latency of internal pulse
        preq[0] = 1;
        tick("R11"); expect_out("R11", 0, 0);
        tick("R4");  expect_out("R4", 1, 0);
        drain();

        // R3 masked timer stays pending; R8 two blocked cycles after mask write
        preq[4] = 1;
        for (int c = 0; c < 4; c++) begin tick("R3"); expect_out("R3", 0, 0); end
        mask_wr = 1; mask_wd = 13'h1FFE;
        tick("R8"); expect_out("R8", 0, 0);
        tick("R8"); expect_out("R8", 0, 0);
        tick("R3"); expect_out("R3", 1, 10);
        drain();

        // R2 simultaneous requests retired in priority order
        preq = 7'b0011110;
        wait_take("R2", 4, 4);
        done = 1; wait_take("R2", 5, 4);
        done = 1; wait_take("R2", 7, 4);
        done = 1; wait_take("R2", 10, 4);
        drain();

        // R5 level withdrawn while disabled is lost, edge is kept
        goff = 1; tick("R9");
        pin_n[2] = 0; pin_n[3] = 0;
        for (int c = 0; c < 4; c++) tick("R5");
        pin_n[2] = 1; pin_n[3] = 1;
        for (int c = 0; c < 4; c++) tick("R5");
        gon = 1;
        wait_take("R5", 6, 5);
        drain();
        for (int c = 0; c < 3; c++) begin tick("R5"); expect_out("R5", 0, 0); end
        pin_n[1] = 0;
        wait_take("R5", 2, 6);
        done = 1; wait_take("R5", 2, 6);
        pin_n[1] = 1;
        drain();

        // R7 force, clear, force on level source
        goff = 1; tick("R7");
        fc_wr = 1; fc_s = 13'h0800; tick("R7");
        fc_wr = 1; fc_c = 13'h0800; tick("R7");
        fc_wr = 1; fc_s = 13'h0004; tick("R7");
        gon = 1;
        for (int c = 0; c < 5; c++) begin tick("R7"); expect_out("R7", 0, 0); end
        fc_wr = 1; fc_s = 13'h1000; fc_c = 13'h1000;
        wait_take("R7", 12, 4);
        drain();

        // R9 disable blocks power-down too
        goff = 1; tick("R9");
        preq[0] = 1;
        for (int c = 0; c < 4; c++) begin tick("R9"); expect_out("R9", 0, 0); end
        gon = 1;
        wait_take("R9", 0, 4);
        drain();

        // R10 sequential then nested
        preq[4] = 1; wait_take("R10", 10, 4);
        preq[0] = 1;
        for (int c = 0; c < 4; c++) begin tick("R10"); expect_out("R10", 0, 0); end
        done = 1; wait_take("R10", 0, 4);
        drain();
        ctl_wr = 1; ctl_wd = 4'b1000; tick("R10");
        preq[4] = 1; wait_take("R10", 10, 4);
        preq[1] = 1; wait_take("R10", 4, 4);
        drain();

        // R6 configurable pin latency in level then edge mode
        ctl_wr = 1; ctl_wd = 4'b0000; tick("R6");
        pin_n[0] = 0;
        tick("R6"); expect_out("R6", 0, 0);
        tick("R6"); expect_out("R6", 0, 0);
        tick("R6"); expect_out("R6", 1, 1);
        pin_n[0] = 1;
        drain();
        ctl_wr = 1; ctl_wd = 4'b0100; tick("R6");
        pin_n[0] = 0;
        tick("R6"); expect_out("R6", 0, 0);
        tick("R6"); expect_out("R6", 0, 0);
        tick("R6"); expect_out("R6", 0, 0);
        tick("R6"); expect_out("R6", 1, 1);
        pin_n[0] = 1;
        drain();

        // random mix checked against the model
        for (int c = 0; c < 4000; c++) begin
            for (int p = 0; p < 6; p++) if (($urandom % 8) == 0) pin_n[p] = ~pin_n[p];
            preq = 7'($urandom & $urandom & $urandom);
            if (($urandom % 16) == 0) begin mask_wr = 1; mask_wd = 13'($urandom); end
            if (($urandom % 32) == 0) begin ctl_wr = 1; ctl_wd = 4'($urandom); end
            if (($urandom % 16) == 0) begin
                fc_wr = 1; fc_s = 13'($urandom & $urandom); fc_c = 13'($urandom & $urandom);
            end
            goff = (($urandom % 64) == 0);
            gon  = (($urandom % 8) == 0);
            done = (($urandom % 4) == 0);
            tick("R2 random");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule